// File: doc/BRIEF.md
# Word FIFO Pair with Interrupt Status

This block sits between a register bus and the bit engine of a serial bus master. It holds two 32-bit word queues. The transmit queue is filled by software and drained by the engine. The receive queue is filled by the engine and drained by software. Software programs a trigger level for each queue and can empty either queue with a flush bit that clears itself. It reads how many transmit slots are free and how many receive words are waiting.

All interrupt causes share one status word. The data-request causes follow the queue levels. Error, overflow, underflow and completion causes are sticky and are cleared by writing one to them. A mask selects which causes drive the interrupt line. Packet completion always drives the line, whatever its mask bit holds.

The register port uses single-cycle strobes. Read data is combinational from the address, and a receive-port read pops the queue at that clock edge. Word addresses are 0 control, 1 queue status, 2 mask, 3 interrupt status, 4 transmit port (write) and 5 receive port (read).

Top module: `word_fifo_irq_ctrl`

## Requirements
- R1: After reset the control register and the mask read 0. The queue status reads 0x80 (8 free transmit slots, 0 receive words). The interrupt status reads 0x02, and the interrupt line is low.
- R2: Words written to address 4 leave at the engine transmit side in write order. Queue status bits 7:4 hold the number of free transmit slots, out of 8. Engine transmit data is valid only while the transmit-available output is high.
- R3: Words pushed by the engine are read from address 5 in push order. Queue status bits 3:0 hold the number of waiting receive words.
- R4: A write to address 4 while no transmit slot is free is dropped and sets status bit 5.
- R5: A read of address 5 while the receive queue is empty returns 0 and sets status bit 4.
- R6: Writing 1 to control bit 1 empties the transmit queue, and writing 1 to control bit 0 empties the receive queue. Each bit reads 1 in the cycle after the write, then returns to 0 once the queue is empty.
- R7: Control bits 7:5 hold the transmit trigger level T, and bits 4:2 hold the receive trigger level R. Status bit 1 is 1 exactly while at least T+1 slots are free. Status bit 0 is 1 exactly while at least R+1 words are waiting.
- R8: Writing 1 to a sticky status bit (7..2) clears it, and writing 0 leaves it. Such writes do not change bits 1 and 0. A new event in the same cycle as the clear wins over the clear.
- R9: Engine strobes set status bits as follows: packet done sets bit 7, all done sets bit 6, no acknowledge sets bit 3, and arbitration lost sets bit 2.
- R10: The mask (address 2) has the same layout as the status word, and 1 enables a cause. One cycle after the status or mask changes, the interrupt line shows OR(status AND mask) OR status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| eng_tx_pop | input | 1 | Engine takes one transmit word |
| eng_tx_data | output | 32 | Transmit word at queue head |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers one receive word |
| eng_rx_data | input | 32 | Receive word |
| eng_pkt_done | input | 1 | Packet complete strobe |
| eng_all_done | input | 1 | All packets complete strobe |
| eng_nack | input | 1 | No-acknowledge strobe |
| eng_arb_lost | input | 1 | Arbitration-lost strobe |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench fills the transmit queue one word past full. A design that lets the extra word overwrite the head would hand the engine the wrong first word, and a design that misses the flag would leave bit 5 clear. It reads the empty receive queue, which catches a stale word or a missing underflow flag. It probes both trigger fields at the exact N+1 boundary, where an off-by-one comparison shows up. It reads each flush bit one cycle after the write and again one cycle later, which exposes a bit that never clears or a flush that leaves old counts. It also raises packet completion with a zero mask and clears causes by writing ones, so a design that masks completion, or that clears on zero writes or clears the level-driven request bits, gives the wrong interrupt line or status.

// File: rtl/wfic_pkg.sv
package wfic_pkg;
    // Register word addresses
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_QSTAT = 3'd1;
    localparam logic [2:0] A_MASK  = 3'd2;
    localparam logic [2:0] A_ISTAT = 3'd3;
    localparam logic [2:0] A_TXP   = 3'd4;
    localparam logic [2:0] A_RXP   = 3'd5;
    // Interrupt cause bit positions
    localparam int B_PKT   = 7;
    localparam int B_ALL   = 6;
    localparam int B_OVF   = 5;
    localparam int B_UNF   = 4;
    localparam int B_NACK  = 3;
    localparam int B_ARB   = 2;
    localparam int B_TXREQ = 1;
    localparam int B_RXREQ = 0;
    // Causes held until written with one; the rest follow queue level
    localparam logic [7:0] STICKY = 8'hFC;
    // Control field positions
    localparam int C_RXFL = 0;
    localparam int C_TXFL = 1;
    localparam int C_RXTRIG = 2;
    localparam int C_TXTRIG = 5;
endpackage

// File: rtl/word_fifo.sv
// Synchronous word queue with flush.
// Assumes: a push while full and a pop while empty are ignored (the caller
// flags them); flush wins over push and pop in the same cycle.
module word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem[rp];

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/irq_cause_reg.sv
// Interrupt status word and registered interrupt line.
// Assumes: sticky bits set on events and clear on write-one, set wins;
// level bits pass straight through; bit PKT_BIT ignores the mask.
module irq_cause_reg #(
    parameter int          NCAUSE  = 8,
    parameter logic [7:0]  STICKY  = 8'hFC,
    parameter int          PKT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] set_vec,
    input  logic [NCAUSE-1:0] clr_vec,
    input  logic [NCAUSE-1:0] lvl_vec,
    input  logic [NCAUSE-1:0] mask,
    output logic [NCAUSE-1:0] status,
    output logic              irq
);
    logic [NCAUSE-1:0] held;

    assign status = (held & STICKY[NCAUSE-1:0]) | (lvl_vec & ~STICKY[NCAUSE-1:0]);

    // Sticky cause capture with write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= ((held & ~clr_vec) | set_vec) & STICKY[NCAUSE-1:0];
    end

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(status & mask)) | status[PKT_BIT];
    end
endmodule

// File: rtl/word_fifo_irq_ctrl.sv
// Transmit/receive word queues with control, level and interrupt registers.
// Assumes: DEPTH <= 15 so counts fit the 4-bit status fields; single-cycle
// register strobes; read data is combinational and RX-port reads pop.
module word_fifo_irq_ctrl
    import wfic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int TRIG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_pkt_done,
    input  logic              eng_all_done,
    input  logic              eng_nack,
    input  logic              eng_arb_lost,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int CMP_W = (CNT_W > TRIG_W ? CNT_W : TRIG_W) + 1;
    localparam logic [CNT_W-1:0] DEPTHC = CNT_W'(DEPTH);

    logic [TRIG_W-1:0] trig_tx, trig_rx;
    logic              flush_tx, flush_rx;
    logic [7:0]        mask_q, status, set_vec, clr_vec, lvl_vec;
    logic [CNT_W-1:0]  tx_count, rx_count, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              wr_ctrl, wr_txp, rd_rxp, ovf_ev, unf_ev;

    assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
    assign wr_txp  = reg_wr && reg_addr == A_TXP && !flush_tx;
    assign rd_rxp  = reg_rd && reg_addr == A_RXP && !flush_rx;
    assign ovf_ev  = wr_txp && tx_full;
    assign unf_ev  = rd_rxp && rx_empty;
    assign tx_free = DEPTHC - tx_count;

    // Control fields and self-clearing flush requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_tx  <= '0;
            trig_rx  <= '0;
            flush_tx <= 1'b0;
            flush_rx <= 1'b0;
        end else if (wr_ctrl) begin
            trig_tx  <= reg_wdata[C_TXTRIG +: TRIG_W];
            trig_rx  <= reg_wdata[C_RXTRIG +: TRIG_W];
            flush_tx <= reg_wdata[C_TXFL];
            flush_rx <= reg_wdata[C_RXFL];
        end else begin
            flush_tx <= 1'b0;
            flush_rx <= 1'b0;
        end
    end

    // Interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK)  mask_q <= reg_wdata[7:0];
    end

    word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(wr_txp), .wdata(reg_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(rd_rxp), .rdata(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_avail = !tx_empty;

    // Cause vectors for the status word
    always_comb begin
        set_vec         = '0;
        set_vec[B_PKT]  = eng_pkt_done;
        set_vec[B_ALL]  = eng_all_done;
        set_vec[B_OVF]  = ovf_ev;
        set_vec[B_UNF]  = unf_ev;
        set_vec[B_NACK] = eng_nack;
        set_vec[B_ARB]  = eng_arb_lost;
        clr_vec = (reg_wr && reg_addr == A_ISTAT) ? reg_wdata[7:0] : 8'h00;
        lvl_vec          = '0;
        lvl_vec[B_TXREQ] = CMP_W'(tx_free)  >= CMP_W'(trig_tx) + CMP_W'(1);
        lvl_vec[B_RXREQ] = CMP_W'(rx_count) >= CMP_W'(trig_rx) + CMP_W'(1);
    end

    irq_cause_reg #(.NCAUSE(8), .STICKY(STICKY), .PKT_BIT(B_PKT)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .lvl_vec(lvl_vec), .mask(mask_q), .status(status), .irq(irq)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_TXTRIG +: TRIG_W] = trig_tx;
                reg_rdata[C_RXTRIG +: TRIG_W] = trig_rx;
                reg_rdata[C_TXFL] = flush_tx;
                reg_rdata[C_RXFL] = flush_rx;
            end
            A_QSTAT: begin
                reg_rdata[7:4] = 4'(tx_free);
                reg_rdata[3:0] = 4'(rx_count);
            end
            A_MASK:  reg_rdata[7:0] = mask_q;
            A_ISTAT: reg_rdata[7:0] = status;
            A_RXP:   reg_rdata[DATA_W-1:0] = rx_head;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/word_fifo_irq_checker.sv
// Property checker for word_fifo_irq_ctrl, attached by bind.
module word_fifo_irq_checker
    import wfic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             eng_nack,
    input logic             eng_arb_lost,
    input logic             flush_tx,
    input logic [CNT_W-1:0] tx_free,
    input logic [CNT_W-1:0] rx_count,
    input logic             flush_rx,
    input logic [7:0]       status,
    input logic [7:0]       mask_q,
    input logic             irq
);
    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXP && !flush_tx && tx_free == 0) |=> status[B_OVF]); // R4
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RXP && !flush_rx && rx_count == 0) |=> status[B_UNF]); // R5
    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_tx && !(reg_wr && reg_addr == A_CTRL && reg_wdata[C_TXFL]))
        |=> (!flush_tx && tx_free == CNT_W'(DEPTH))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ISTAT && reg_wdata[B_ARB] && !eng_arb_lost) |=> !status[B_ARB]); // R8
    AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack |=> status[B_NACK]); // R9
    AST_PKT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_PKT] |=> irq); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (((status & mask_q) == 8'h00) && !status[B_PKT]) |=> !irq); // R10
endmodule

bind word_fifo_irq_ctrl word_fifo_irq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eng_nack(eng_nack),
    .eng_arb_lost(eng_arb_lost), .flush_tx(flush_tx), .tx_free(tx_free),
    .rx_count(rx_count), .flush_rx(flush_rx), .status(status),
    .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_word_fifo_irq_ctrl.sv
module tb_word_fifo_irq_ctrl;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        eng_tx_pop = 0, eng_tx_avail, eng_rx_push = 0;
    logic [31:0] eng_tx_data, eng_rx_data = 0;
    logic        eng_pkt_done = 0, eng_all_done = 0, eng_nack = 0, eng_arb_lost = 0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    word_fifo_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_pkt_done(eng_pkt_done), .eng_all_done(eng_all_done),
        .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic eng_pop(output logic [31:0] d);
        @(negedge clk); #1 d = eng_tx_data; eng_tx_pop = 1;
        @(posedge clk); #1 eng_tx_pop = 0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
        @(posedge clk); #1 eng_rx_push = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); check("R1 ctrl", d, 0);
        rd(3'd1, d); check("R1 qstat", d, 32'h80);
        rd(3'd2, d); check("R1 mask", d, 0);
        rd(3'd3, d); check("R1 istat", d, 32'h02);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_tx_overflow;
        logic [31:0] d;
        for (int i = 0; i < 3; i++) wr(3'd4, 32'hA000_0000 + i);
        rd(3'd1, d); check("R2 free after 3", d, 32'h50);
        for (int i = 3; i < 9; i++) wr(3'd4, 32'hA000_0000 + i);
        rd(3'd1, d); check("R4 free when full", d, 32'h00);
        rd(3'd3, d); check("R4 ovf bit", d[5], 1);
        for (int i = 0; i < 8; i++) begin
            eng_pop(d); check("R2 tx order", d, 32'hA000_0000 + i);
        end
        check("R4 extra word dropped", eng_tx_avail, 0);
        wr(3'd3, 32'h0); rd(3'd3, d); check("R8 zero write keeps", d[5], 1);
        wr(3'd3, 32'h20); rd(3'd3, d); check("R8 w1c ovf", d[5], 0);
    endtask

    task automatic t_rx_underflow;
        logic [31:0] d;
        for (int i = 0; i < 3; i++) eng_push(32'hB000_0010 + i);
        rd(3'd1, d); check("R3 rx count", d, 32'h83);
        for (int i = 0; i < 3; i++) begin
            rd(3'd5, d); check("R3 rx order", d, 32'hB000_0010 + i);
        end
        rd(3'd5, d); check("R5 empty read zero", d, 0);
        rd(3'd3, d); check("R5 unf bit", d[4], 1);
        wr(3'd3, 32'h13); rd(3'd3, d);
        check("R8 clear unf keeps level bits", d, 32'h02);
    endtask

    task automatic t_trigger;
        logic [31:0] d;
        wr(3'd0, (32'd7 << 5) | (32'd2 << 2));
        rd(3'd3, d); check("R7 tx trig7 all free", d[1], 1);
        wr(3'd4, 32'h1);
        rd(3'd3, d); check("R7 tx trig7 seven free", d[1], 0);
        eng_push(32'h1); eng_push(32'h2);
        rd(3'd3, d); check("R7 rx trig2 two held", d[0], 0);
        eng_push(32'h3);
        rd(3'd3, d); check("R7 rx trig2 three held", d[0], 1);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h3);
        rd(3'd0, d); check("R6 flush bits set", d, 32'h3);
        rd(3'd0, d); check("R6 flush bits cleared", d, 32'h0);
        rd(3'd1, d); check("R6 queues empty", d, 32'h80);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        @(negedge clk); eng_nack = 1; eng_arb_lost = 1; eng_all_done = 1;
        @(posedge clk); #1 eng_nack = 0; eng_arb_lost = 0; eng_all_done = 0;
        rd(3'd3, d); check("R9 nack arb all bits", d, 32'h4E);
        idle(2); check("R10 masked quiet", irq, 0);
        wr(3'd2, 32'h08); idle(2); check("R10 nack enabled", irq, 1);
        wr(3'd3, 32'h4C); idle(2); check("R10 cleared drops", irq, 0);
        wr(3'd2, 32'h02); idle(2); check("R10 tx request enabled", irq, 1);
        wr(3'd2, 32'h00); idle(2);
        @(negedge clk); eng_pkt_done = 1;
        @(posedge clk); #1 eng_pkt_done = 0;
        idle(2); check("R10 pkt done ignores mask", irq, 1);
        rd(3'd3, d); check("R9 pkt bit", d[7], 1);
        wr(3'd3, 32'h80); idle(2); check("R10 pkt cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_tx_overflow();
        t_rx_underflow();
        t_trigger();
        t_flush();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule